// File: doc/BRIEF.md
# Multi-CPU Interrupt Mapper

The block routes 128 level-sensitive interrupt sources to four CPUs. Each CPU owns a private bank holding a mask pair, a 3-bit route code for every source, and two 64-bit mailboxes. Each CPU has five interrupt output lines. A source reaches a CPU only while that CPU's mask bit for it is clear. It then drives the output line that the CPU's route code selects.

The sources form a low half (indices 0..63) and a high half (indices 64..127). High-half bit 0 (source 64) is never active. High-half bit 12 (source 76) is owned by the mailboxes: in each bank it is the OR of bits 63:48 of that bank's mailbox 0, so one CPU can interrupt another by setting bits there. A shared pending register catches single-cycle event pulses. Its bits act as sources until software clears them by writing ones.

A single-cycle register port gives access to all state. The address is `{cpu[1:0], offset[7:0]}` and the data path is 64 bits wide. Offset bit 0 selects the half, or the mailbox, for the paired registers.

Top module: `irqmap`

## Requirements
- R1: After reset every mask bit is 1, every route code, mailbox and pending bit is 0, and irq_o is all zero.
- R2: Address bits 9:8 select the CPU bank. A write changes only the selected CPU's mask, route codes and mailboxes.
- R3: The mask is read/write at offset 0x80 (low half) and 0x81 (high half); a mask bit of 1 blocks the source. Status is read-only at 0x82 and 0x83. Status bit i = effective source i AND NOT mask bit i. The effective source is src_i OR pending, after the overrides of R6 and R8.
- R4: The route code of source s is at offset s (0..127), in bits 2:0 of the data. Output irq_o[c*5+n] is the OR of CPU c's status bits whose code equals n.
- R5: Route codes 5, 6 and 7 connect the source to no output line.
- R6: Source 64 (high-half bit 0) is never active, whatever src_i and pending hold.
- R7: Mailbox m (m = 0, 1) is read/write at 0x88+m. A write to 0x8A+m ORs the data into it. A write to 0x8C+m clears the bits written as 1. Reads of 0x8A..0x8D return 0.
- R8: Source 76 of CPU c equals the OR of bits 63:48 of CPU c's mailbox 0; src_i[76] is ignored.
- R9: A 1 on ldt_i sets the matching shared pending bit, which is readable at 0x84 and 0x85 in every bank. Writing ones to 0x86 or 0x87 in any bank clears those bits, but a pulse on ldt_i in the same cycle wins.
- R10: A read returns rsp_valid_o and its data one cycle after the request. Writes take effect at the clock edge of the request. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Level interrupt sources, low half bits 63:0 |
| ldt_i | input | 128 | Event pulses that set pending bits |
| req_valid_i | input | 1 | Register request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 10 | {cpu, offset} |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data |
| irq_o | output | 20 | Output lines, bit c*5+n = CPU c line n |

## Verification
The hardest state to reach is a source that is held up by internal state rather than by src_i. One case is the mailbox source, which is raised only by bits 63:48 of one CPU's mailbox 0. The other is a pending bit that receives a new pulse in the same cycle as its clear. The stimulus builds both directly. It sets mailbox bits through the set port and watches only the owning CPU's line move. It also pulses ldt_i in the same cycle as a clear write. A seeded random phase then mixes mask, route, mailbox, pending and source changes. After each step it compares all 20 lines, and a random status read, against a model in the bench.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
  localparam int HALF_W   = 64;
  localparam int NSRC     = 2 * HALF_W;
  localparam int CODE_W   = 3;
  localparam int OFS_W    = 8;
  localparam int MBOX_BIT = 12;   // high-half bit fed by mailbox 0
  localparam int MSG_LO   = 48;   // mailbox 0 bits [63:MSG_LO] raise it
  localparam logic [OFS_W-1:0] OFS_MASK = 8'h80;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h82;
  localparam logic [OFS_W-1:0] OFS_PEND = 8'h84;
  localparam logic [OFS_W-1:0] OFS_PCLR = 8'h86;
  localparam logic [OFS_W-1:0] OFS_MBOX = 8'h88;
  localparam logic [OFS_W-1:0] OFS_MSET = 8'h8A;
  localparam logic [OFS_W-1:0] OFS_MCLR = 8'h8C;
endpackage

// File: rtl/irqmap_ldt.sv
module irqmap_ldt
  import irqmap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   ldt_i,
  input  logic              clr_we_i,
  input  logic              clr_half_i,
  input  logic [HALF_W-1:0] clr_data_i,
  output logic [NSRC-1:0]   pend_o
);
  logic [NSRC-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_we_i) begin
      if (clr_half_i) clr_vec[NSRC-1:HALF_W] = clr_data_i;
      else            clr_vec[HALF_W-1:0]    = clr_data_i;
    end
  end

  // new pulse wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_vec) | ldt_i;
  end

  // R9
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ldt_i) |=> ((pend_o & $past(ldt_i)) == $past(ldt_i)));
  // R9
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((pend_o & $past(clr_vec & ~ldt_i)) == '0));
endmodule

// File: rtl/irqmap_route.sv
module irqmap_route
  import irqmap_pkg::*;
#(
  parameter int N_LINE = 5
) (
  input  logic [NSRC-1:0]   stat_i,
  input  logic [CODE_W-1:0] code_i [NSRC],
  output logic [N_LINE-1:0] line_o
);
  for (genvar n = 0; n < N_LINE; n++) begin : g_line
    always_comb begin
      line_o[n] = 1'b0;
      for (int s = 0; s < NSRC; s++)
        if (code_i[s] == CODE_W'(n)) line_o[n] = line_o[n] | stat_i[s];
    end
  end
endmodule

// File: rtl/irqmap_bank.sv
module irqmap_bank
  import irqmap_pkg::*;
#(
  parameter int N_LINE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic [N_LINE-1:0] irq_o
);
  logic [HALF_W-1:0] mask_q [2];
  logic [HALF_W-1:0] mbox_q [2];
  logic [CODE_W-1:0] map_q  [NSRC];
  logic [NSRC-1:0]   src_eff, status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int h = 0; h < 2; h++) begin
        mask_q[h] <= '1;
        mbox_q[h] <= '0;
      end
      for (int s = 0; s < NSRC; s++) map_q[s] <= '0;
    end else if (we_i) begin
      if (!ofs_i[OFS_W-1])
        map_q[ofs_i[OFS_W-2:0]] <= wdata_i[CODE_W-1:0];
      else case ({ofs_i[OFS_W-1:1], 1'b0})
        OFS_MASK: mask_q[ofs_i[0]] <= wdata_i;
        OFS_MBOX: mbox_q[ofs_i[0]] <= wdata_i;
        OFS_MSET: mbox_q[ofs_i[0]] <= mbox_q[ofs_i[0]] | wdata_i;
        OFS_MCLR: mbox_q[ofs_i[0]] <= mbox_q[ofs_i[0]] & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    src_eff                   = src_i;
    src_eff[HALF_W]           = 1'b0;
    src_eff[HALF_W+MBOX_BIT]  = |mbox_q[0][HALF_W-1:MSG_LO];
    status                    = src_eff & ~{mask_q[1], mask_q[0]};
  end

  always_comb begin
    rdata_o = '0;
    if (!ofs_i[OFS_W-1])
      rdata_o = HALF_W'(map_q[ofs_i[OFS_W-2:0]]);
    else case ({ofs_i[OFS_W-1:1], 1'b0})
      OFS_MASK: rdata_o = mask_q[ofs_i[0]];
      OFS_STAT: rdata_o = ofs_i[0] ? status[NSRC-1:HALF_W] : status[HALF_W-1:0];
      OFS_MBOX: rdata_o = mbox_q[ofs_i[0]];
      default:  rdata_o = '0;
    endcase
  end

  irqmap_route #(.N_LINE(N_LINE)) u_route (
    .stat_i (status),
    .code_i (map_q),
    .line_o (irq_o)
  );

  // R3
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ofs_i[OFS_W-1:1] == OFS_MASK[OFS_W-1:1])
      |=> (mask_q[$past(ofs_i[0])] == $past(wdata_i)));
  // R7
  mbox_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ofs_i[OFS_W-1:1] == OFS_MSET[OFS_W-1:1])
      |=> ((mbox_q[$past(ofs_i[0])] & $past(wdata_i)) == $past(wdata_i)));
  // R7
  mbox_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ofs_i[OFS_W-1:1] == OFS_MCLR[OFS_W-1:1])
      |=> ((mbox_q[$past(ofs_i[0])] & $past(wdata_i)) == '0));
  // R4
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|status));
endmodule

// File: rtl/irqmap.sv
module irqmap
  import irqmap_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int N_LINE = 5,
  localparam int CPU_W  = $clog2(N_CPU),
  localparam int ADDR_W = CPU_W + OFS_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NSRC-1:0]         src_i,
  input  logic [NSRC-1:0]         ldt_i,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [HALF_W-1:0]       req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [HALF_W-1:0]       rsp_rdata_o,
  output logic [N_CPU*N_LINE-1:0] irq_o
);
  logic [CPU_W-1:0]  cpu_sel;
  logic [OFS_W-1:0]  ofs;
  logic              wr, rd, pend_hit;
  logic [NSRC-1:0]   pend, src_pend;
  logic [HALF_W-1:0] bank_rd [N_CPU];
  logic [HALF_W-1:0] rd_mux;

  assign cpu_sel  = req_addr_i[ADDR_W-1:OFS_W];
  assign ofs      = req_addr_i[OFS_W-1:0];
  assign wr       = req_valid_i & req_write_i;
  assign rd       = req_valid_i & ~req_write_i;
  assign pend_hit = (ofs[OFS_W-1:1] == OFS_PEND[OFS_W-1:1]);
  assign src_pend = src_i | pend;

  irqmap_ldt u_ldt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ldt_i      (ldt_i),
    .clr_we_i   (wr && ofs[OFS_W-1:1] == OFS_PCLR[OFS_W-1:1]),
    .clr_half_i (ofs[0]),
    .clr_data_i (req_wdata_i),
    .pend_o     (pend)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    irqmap_bank #(.N_LINE(N_LINE)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_pend),
      .we_i    (wr && cpu_sel == CPU_W'(c)),
      .ofs_i   (ofs),
      .wdata_i (req_wdata_i),
      .rdata_o (bank_rd[c]),
      .irq_o   (irq_o[c*N_LINE +: N_LINE])
    );
  end

  always_comb begin
    if (pend_hit) rd_mux = ofs[0] ? pend[NSRC-1:HALF_W] : pend[HALF_W-1:0];
    else          rd_mux = bank_rd[cpu_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
    end
  end

  // R10
  rsp_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rsp_valid_o);
  // R10
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rsp_valid_o);
endmodule

// File: tb/irqmap_test.sv
module irqmap_test;
  logic         clk = 0, rst_n = 0;
  logic [127:0] src = '0, ldt = '0;
  logic         req_valid = 0, req_write = 0;
  logic [9:0]   req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [63:0]  rsp_rdata;
  logic [19:0]  irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0]  m_mask [4][2];
  logic [63:0]  m_mbox [4][2];
  logic [2:0]   m_map  [4][128];
  logic [127:0] m_pend;

  always #4 clk = ~clk;

  irqmap uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .ldt_i(ldt),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq)
  );

  function automatic logic [127:0] f_eff(int c);
    logic [127:0] e = src | m_pend;
    e[64] = 1'b0;
    e[76] = |m_mbox[c][0][63:48];
    return e;
  endfunction

  function automatic logic [127:0] f_stat(int c);
    return f_eff(c) & ~{m_mask[c][1], m_mask[c][0]};
  endfunction

  function automatic logic [4:0] f_irq(int c);
    logic [127:0] st = f_stat(c);
    logic [4:0] l = '0;
    for (int s = 0; s < 128; s++)
      if (m_map[c][s] < 5 && st[s]) l[m_map[c][s]] = 1'b1;
    return l;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_irq(string req);
    for (int c = 0; c < 4; c++) chk(req, 64'(irq[c*5 +: 5]), 64'(f_irq(c)));
  endtask

  task automatic model_wr(int c, logic [7:0] o, logic [63:0] d);
    if (!o[7]) m_map[c][o[6:0]] = d[2:0];
    else case (o)
      8'h80, 8'h81: m_mask[c][o[0]] = d;
      8'h86: m_pend[63:0]   = m_pend[63:0]   & ~d;
      8'h87: m_pend[127:64] = m_pend[127:64] & ~d;
      8'h88, 8'h89: m_mbox[c][o[0]] = d;
      8'h8A, 8'h8B: m_mbox[c][o[0]] = m_mbox[c][o[0]] | d;
      8'h8C, 8'h8D: m_mbox[c][o[0]] = m_mbox[c][o[0]] & ~d;
      default: ;
    endcase
  endtask

  task automatic wr(int c, logic [7:0] o, logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = {2'(c), o}; req_wdata = d;
    @(posedge clk);
    model_wr(c, o, d);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(int c, logic [7:0] o, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = {2'(c), o};
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic set_src(logic [127:0] v);
    @(negedge clk);
    src = v;
    #1;
  endtask

  task automatic pulse(logic [127:0] v);
    @(negedge clk);
    ldt = v;
    @(posedge clk);
    m_pend = m_pend | v;
    @(negedge clk);
    ldt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    for (int c = 0; c < 4; c++) begin
      m_mask[c][0] = '1; m_mask[c][1] = '1;
      m_mbox[c][0] = '0; m_mbox[c][1] = '0;
      for (int s = 0; s < 128; s++) m_map[c][s] = '0;
    end
    m_pend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    rd(0, 8'h80, d); chk("R1 mask lo", d, '1);
    rd(3, 8'h81, d); chk("R1 mask hi", d, '1);
    rd(2, 8'h05, d); chk("R1 map", d, 0);
    rd(1, 8'h88, d); chk("R1 mbox", d, 0);
    rd(0, 8'h84, d); chk("R1 pend", d, 0);

    // R3 / R2 status through mask, bank isolation
    wr(1, 8'h80, ~(64'd1 << 3));
    set_src(128'd1 << 3);
    rd(1, 8'h82, d); chk("R3 status lo", d, 64'd1 << 3);
    rd(0, 8'h82, d); chk("R2 other bank status", d, 0);
    rd(0, 8'h80, d); chk("R2 other bank mask", d, '1);
    rd(1, 8'h80, d); chk("R3 mask readback", d, ~(64'd1 << 3));

    // R4 route code
    wr(1, 8'h03, 64'd2);
    chk("R4 line2", 64'(irq), 64'(20'b1 << 7));
    rd(1, 8'h03, d); chk("R4 map readback", d, 2);
    chk_irq("R4 model");

    // R5 code out of range
    wr(1, 8'h03, 64'd6);
    chk("R5 no route", 64'(irq), 0);
    wr(1, 8'h03, 64'd7);
    chk("R5 code7", 64'(irq), 0);

    // R6 high bit 0 silent
    wr(2, 8'h81, '0);
    set_src(128'd1 << 64);
    rd(2, 8'h83, d); chk("R6 hi bit0", d, 0);
    chk("R6 irq", 64'(irq), 0);

    // R8 mailbox raises source 76 in owner only; src_i[76] ignored
    wr(2, 8'h4C, 64'd4);
    set_src(128'd1 << 76);
    chk("R8 src76 ignored", 64'(irq), 0);
    wr(2, 8'h8A, 64'hFFFF_FFFF_FFFF);
    chk("R8 low msg bits", 64'(irq), 0);
    wr(2, 8'h8A, 64'd1 << 50);
    chk("R8 mbox raise", 64'(irq), 64'(20'b1 << 14));
    wr(2, 8'h8C, 64'd1 << 50);
    chk("R8 mbox cleared", 64'(irq), 0);

    // R7 mailbox ports
    rd(2, 8'h88, d); chk("R7 mbox set/clr", d, 64'hFFFF_FFFF_FFFF);
    rd(2, 8'h8A, d); chk("R7 set reads 0", d, 0);
    rd(2, 8'h8D, d); chk("R7 clr reads 0", d, 0);
    wr(3, 8'h89, 64'hA5A5_0000_1234_5678);
    rd(3, 8'h89, d); chk("R7 mbox1 rw", d, 64'hA5A5_0000_1234_5678);

    // R9 pending shared, set wins over clear
    set_src('0);
    wr(0, 8'h80, ~(64'd1 << 10));
    wr(0, 8'h0A, 64'd1);
    pulse(128'd1 << 10);
    rd(3, 8'h84, d); chk("R9 pend shared", d, 64'd1 << 10);
    chk("R9 pend irq", 64'(irq), 64'(20'b1 << 1));
    @(negedge clk);
    ldt = 128'd1 << 10;
    req_valid = 1; req_write = 1; req_addr = {2'd2, 8'h86}; req_wdata = 64'd1 << 10;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0; ldt = '0;
    rd(0, 8'h84, d); chk("R9 set wins", d, 64'd1 << 10);
    wr(2, 8'h86, 64'd1 << 10);
    rd(1, 8'h84, d); chk("R9 cleared", d, 0);
    chk("R9 irq off", 64'(irq), 0);

    // R10 latency and unmapped
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = {2'd0, 8'h90};
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R10 rsp valid", 64'(rsp_valid), 1);
    chk("R10 unmapped", rsp_rdata, 0);
    @(negedge clk);
    chk("R10 rsp drop", 64'(rsp_valid), 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int c = $urandom_range(0, 3);
      int op = $urandom_range(0, 6);
      case (op)
        0: wr(c, 8'h80 + 8'($urandom_range(0, 1)), {$urandom, $urandom});
        1, 2: wr(c, 8'($urandom_range(0, 127)), 64'($urandom_range(0, 7)));
        3: set_src({$urandom, $urandom, $urandom, $urandom});
        4: wr(c, 8'h8A + 8'($urandom_range(0, 1) * 2), {$urandom, $urandom} & 64'hFFFF_0000_0000_0001);
        5: pulse({$urandom, $urandom, $urandom, $urandom} & {4{32'h0101_0101}});
        default: wr(c, 8'h86 + 8'($urandom_range(0, 1)), {$urandom, $urandom});
      endcase
      chk_irq("R4 random");
      begin
        int rc = $urandom_range(0, 3);
        int h = $urandom_range(0, 1);
        logic [127:0] st = f_stat(rc);
        rd(rc, 8'h82 + 8'(h), d);
        chk("R3 random status", d, h ? st[127:64] : st[63:0]);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule